// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address and count engine of a single DMA channel that moves data across a 16-bit bus, one byte or one halfword per transfer. When the channel enable rises, it captures a source start address, a destination start address, a transfer count and the channel configuration. After that, each one-cycle advance strobe (one completed transfer) moves the addresses on to the next access and updates the count. The outputs are the current source and destination addresses together with the byte-lane enables for each. The bus is big-endian: the even byte sits on the upper lane.

The channel runs in one of two modes. In counted mode it stops after the programmed number of transfers and marks the end with a single-cycle terminal pulse. In ring mode, every address that is set to increment wraps inside an aligned window of 32 transfers. The count is not used in ring mode, and the channel keeps running until the enable is dropped. If ring mode is asked for with an incrementing start address that is not window-aligned, the channel refuses to start and raises a configuration error.

Top module: `dma_addr_seq`

## Requirements
- R1: A rising edge of `en` captures `src_start`, `dst_start`, `count_init`, `unit16`, `ring`, `src_inc` and `dst_inc`. The captured values appear on `src_addr`, `dst_addr` and `count` one cycle later. Changes to the configuration inputs while the channel runs have no effect.
- R2: In counted mode, each advance taken while busy lowers `count` by exactly one, for both 8-bit and 16-bit units.
- R3: In 8-bit mode, address bit 0 is kept and an incrementing address steps by one. The lane enables `{upper,lower}` are 2'b10 for an even address and 2'b01 for an odd one.
- R4: In 16-bit mode, bit 0 of each start address is cleared when captured, an incrementing address steps by two, and the lane enables are 2'b11.
- R5: An address that is configured as fixed never changes during a run, in either mode.
- R6: In counted mode, the advance that brings `count` to zero causes a one-cycle `tc_pulse` and clears `busy` on the next cycle. Later advances leave addresses and count unchanged.
- R7: In 8-bit ring mode, an incrementing address keeps its upper 27 bits, adds one to its low 5 bits, and wraps from 5'b11111 to 5'b00000.
- R8: In 16-bit ring mode, an incrementing address keeps its upper 26 bits, adds two to its low 6 bits, and wraps from 6'b111110 to 6'b000000.
- R9: In ring mode, `count` never changes, no `tc_pulse` is produced, and the channel stays busy until `en` goes low. `busy` then drops one cycle later, and advances are ignored from that point on.
- R10: At enable in ring mode, `cfg_err` is set if any incrementing start address has nonzero low 5 bits (8-bit unit) or low 6 bits (16-bit unit). In that case `busy` stays low. `cfg_err` holds its value until the next enable rise.
- R11: In counted mode, a captured count of zero leaves `busy` low.
- R12: After reset, all outputs are zero. Both lane enables are 2'b00 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable level; a rising edge starts a run |
| unit16 | input | 1 | Transfer unit: 1 = 16-bit, 0 = 8-bit |
| ring | input | 1 | 1 = ring mode, 0 = counted mode |
| src_inc | input | 1 | Source address increments (1) or stays fixed (0) |
| dst_inc | input | 1 | Destination address increments (1) or stays fixed (0) |
| src_start | input | 32 | Source start address |
| dst_start | input | 32 | Destination start address |
| count_init | input | 16 | Number of transfers in counted mode |
| advance | input | 1 | One-cycle strobe: a transfer has completed |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| src_lanes | output | 2 | Source byte lanes {upper, lower} |
| dst_lanes | output | 2 | Destination byte lanes {upper, lower} |
| count | output | 16 | Remaining transfer count |
| busy | output | 1 | Channel is running |
| tc_pulse | output | 1 | One-cycle terminal count indication |
| cfg_err | output | 1 | Misaligned ring start detected at enable |

## Verification
Every result of the block passes through exactly one register. A value captured at the enable rise, the step that follows an advance, the terminal pulse, and the drop of `busy` after `en` falls are all visible on the cycle after the edge that samples the stimulus. The lane enables are decoded from the registered address, so they follow that address with no further delay. The bench applies stimulus at the falling clock edge and runs a behavioural model on the same rising edge as the design. At the next falling edge it compares every output with the model, so each result is checked in exactly the cycle where it is due.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef struct packed {
        logic unit16;
        logic ring;
        logic src_inc;
        logic dst_inc;
    } chan_cfg_t;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dma_seq_addr_step.sv
module dma_seq_addr_step #(
    parameter int ADDR_W    = 32,
    parameter int WIN8_BITS = 5
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              inc,
    input  logic              unit16,
    input  logic              ring,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] load_addr,
    output logic              start_bad
);
    localparam int WIN16_BITS = WIN8_BITS + 1;
    localparam logic [ADDR_W-1:0] MASK8  = {{(ADDR_W-WIN8_BITS){1'b0}},  {WIN8_BITS{1'b1}}};
    localparam logic [ADDR_W-1:0] MASK16 = {{(ADDR_W-WIN16_BITS){1'b0}}, {WIN16_BITS{1'b1}}};

    logic [ADDR_W-1:0] step_amt;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        step_amt = unit16 ? ADDR_W'(2) : ADDR_W'(1);
        win_mask = unit16 ? MASK16 : MASK8;
        sum      = cur_addr + step_amt;
        if (!inc) begin
            nxt_addr = cur_addr;
        end else if (ring) begin
            nxt_addr = (cur_addr & ~win_mask) | (sum & win_mask);
        end else begin
            nxt_addr = sum;
        end
        load_addr = unit16 ? {start_addr[ADDR_W-1:1], 1'b0} : start_addr;
        start_bad = ring & inc & (|(start_addr & win_mask));
    end
endmodule

// File: rtl/dma_seq_lane_dec.sv
module dma_seq_lane_dec (
    input  logic       addr_lsb,
    input  logic       unit16,
    input  logic       active,
    output logic [1:0] lanes
);
    always_comb begin
        if (!active) begin
            lanes = 2'b00;
        end else if (unit16) begin
            lanes = 2'b11;
        end else begin
            lanes = addr_lsb ? 2'b01 : 2'b10;
        end
    end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int RING_LEN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              unit16,
    input  logic              ring,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic [ADDR_W-1:0] src_start,
    input  logic [ADDR_W-1:0] dst_start,
    input  logic [CNT_W-1:0]  count_init,
    input  logic              advance,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [1:0]        src_lanes,
    output logic [1:0]        dst_lanes,
    output logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              tc_pulse,
    output logic              cfg_err
);
    localparam int WIN8_BITS = $clog2(RING_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        chan_cfg_t         cfg;
        logic              busy;
        logic              tc;
        logic              err;
        logic              en_q;
    } seq_state_t;

    seq_state_t st_d, st_q;

    chan_cfg_t  cfg_in;
    chan_cfg_t  cfg_sel;
    logic       load;

    logic [NUM_SIDES-1:0][ADDR_W-1:0] side_cur;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] side_start;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] side_nxt;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] side_load;
    logic [NUM_SIDES-1:0]             side_inc;
    logic [NUM_SIDES-1:0]             side_bad;
    logic [NUM_SIDES-1:0][1:0]        side_lanes;

    always_comb begin
        cfg_in.unit16  = unit16;
        cfg_in.ring    = ring;
        cfg_in.src_inc = src_inc;
        cfg_in.dst_inc = dst_inc;
        load           = en & ~st_q.en_q;
        cfg_sel        = load ? cfg_in : st_q.cfg;

        side_cur[SIDE_SRC]   = st_q.src;
        side_cur[SIDE_DST]   = st_q.dst;
        side_start[SIDE_SRC] = src_start;
        side_start[SIDE_DST] = dst_start;
        side_inc[SIDE_SRC]   = cfg_sel.src_inc;
        side_inc[SIDE_DST]   = cfg_sel.dst_inc;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dma_seq_addr_step #(
            .ADDR_W    (ADDR_W),
            .WIN8_BITS (WIN8_BITS)
        ) u_step (
            .cur_addr   (side_cur[s]),
            .start_addr (side_start[s]),
            .inc        (side_inc[s]),
            .unit16     (cfg_sel.unit16),
            .ring       (cfg_sel.ring),
            .nxt_addr   (side_nxt[s]),
            .load_addr  (side_load[s]),
            .start_bad  (side_bad[s])
        );

        dma_seq_lane_dec u_lane (
            .addr_lsb (side_cur[s][0]),
            .unit16   (st_q.cfg.unit16),
            .active   (st_q.busy),
            .lanes    (side_lanes[s])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.tc   = 1'b0;
        st_d.en_q = en;
        if (load) begin
            st_d.cfg  = cfg_in;
            st_d.src  = side_load[SIDE_SRC];
            st_d.dst  = side_load[SIDE_DST];
            st_d.cnt  = count_init;
            st_d.err  = |side_bad;
            st_d.busy = ~(|side_bad) & (cfg_in.ring | (|count_init));
        end else if (!en) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy && advance) begin
            st_d.src = side_nxt[SIDE_SRC];
            st_d.dst = side_nxt[SIDE_DST];
            if (!st_q.cfg.ring) begin
                st_d.cnt = st_q.cnt - CNT_ONE;
                if (st_q.cnt == CNT_ONE) begin
                    st_d.tc   = 1'b1;
                    st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_addr  = st_q.src;
    assign dst_addr  = st_q.dst;
    assign src_lanes = side_lanes[SIDE_SRC];
    assign dst_lanes = side_lanes[SIDE_DST];
    assign count     = st_q.cnt;
    assign busy      = st_q.busy;
    assign tc_pulse  = st_q.tc;
    assign cfg_err   = st_q.err;
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int WIN8_BITS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              load,
    input logic              advance,
    input logic              busy,
    input logic              tc_pulse,
    input logic              cfg_err,
    input logic [CNT_W-1:0]  count,
    input logic [ADDR_W-1:0] src_addr,
    input logic [1:0]        src_lanes,
    input logic [1:0]        dst_lanes,
    input logic              q_unit16,
    input logic              q_ring,
    input logic              q_src_inc
);
    assert_tc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    assert_tc_end_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> (count == '0) && !busy);

    assert_wide_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q_unit16) |-> (src_lanes == 2'b11) && (dst_lanes == 2'b11));

    assert_byte_lane_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q_unit16) |-> ($countones(src_lanes) == 1) && ($countones(dst_lanes) == 1));

    assert_idle_lanes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (src_lanes == 2'b00) && (dst_lanes == 2'b00));

    assert_ring_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q_ring && !load) |=> $stable(count));

    assert_err_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    assert_ring_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q_ring && q_src_inc && !q_unit16 && advance && !load)
        |=> $stable(src_addr[ADDR_W-1:WIN8_BITS]));

    assert_en_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
endmodule

bind dma_addr_seq dma_addr_seq_chk #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .WIN8_BITS (WIN8_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (load),
    .advance   (advance),
    .busy      (busy),
    .tc_pulse  (tc_pulse),
    .cfg_err   (cfg_err),
    .count     (count),
    .src_addr  (src_addr),
    .src_lanes (src_lanes),
    .dst_lanes (dst_lanes),
    .q_unit16  (st_q.cfg.unit16),
    .q_ring    (st_q.cfg.ring),
    .q_src_inc (st_q.cfg.src_inc)
);

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, unit16 = 1'b0, ring = 1'b0, src_inc = 1'b0, dst_inc = 1'b0;
    logic [31:0] src_start = '0, dst_start = '0;
    logic [15:0] count_init = '0;
    logic        advance = 1'b0;
    logic [31:0] src_addr, dst_addr;
    logic [1:0]  src_lanes, dst_lanes;
    logic [15:0] count;
    logic        busy, tc_pulse, cfg_err;

    int    tests = 0;
    int    fails = 0;
    int    cycles = 0;
    string tag = "R12";

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .unit16(unit16), .ring(ring),
        .src_inc(src_inc), .dst_inc(dst_inc), .src_start(src_start),
        .dst_start(dst_start), .count_init(count_init), .advance(advance),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_lanes(src_lanes),
        .dst_lanes(dst_lanes), .count(count), .busy(busy),
        .tc_pulse(tc_pulse), .cfg_err(cfg_err)
    );

    // Behavioural reference model
    logic [31:0] m_src, m_dst;
    int          m_cnt;
    logic        m_busy, m_tc, m_err, m_en_q;
    logic        l16, lring, lsi, ldi;

    function automatic logic [31:0] m_step(logic [31:0] a);
        longint st = l16 ? 2 : 1;
        longint w  = l16 ? 64 : 32;
        longint av = a;
        if (lring) return 32'((av - (av % w)) + (((av % w) + st) % w));
        return 32'(av + st);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_src <= '0; m_dst <= '0; m_cnt <= 0; m_busy <= 0; m_tc <= 0;
            m_err <= 0; m_en_q <= 0; l16 <= 0; lring <= 0; lsi <= 0; ldi <= 0;
        end else begin
            m_en_q <= en;
            m_tc   <= 1'b0;
            if (en && !m_en_q) begin
                automatic int  w   = unit16 ? 64 : 32;
                automatic logic e = ring && ((src_inc && (src_start % w) != 0) ||
                                             (dst_inc && (dst_start % w) != 0));
                l16 <= unit16; lring <= ring; lsi <= src_inc; ldi <= dst_inc;
                m_src  <= unit16 ? (src_start & ~32'd1) : src_start;
                m_dst  <= unit16 ? (dst_start & ~32'd1) : dst_start;
                m_cnt  <= count_init;
                m_err  <= e;
                m_busy <= !e && (ring || count_init != 0);
            end else if (!en) begin
                m_busy <= 1'b0;
            end else if (m_busy && advance) begin
                if (lsi) m_src <= m_step(m_src);
                if (ldi) m_dst <= m_step(m_dst);
                if (!lring) begin
                    m_cnt <= m_cnt - 1;
                    if (m_cnt == 1) begin
                        m_tc <= 1'b1;
                        m_busy <= 1'b0;
                    end
                end
            end
        end
    end

    function automatic logic [1:0] m_lanes(logic [31:0] a);
        if (!m_busy) return 2'b00;
        if (l16) return 2'b11;
        return a[0] ? 2'b01 : 2'b10;
    endfunction

    task automatic chk(string f, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("src_addr", src_addr, m_src);
        chk("dst_addr", dst_addr, m_dst);
        chk("src_lanes", 32'(src_lanes), 32'(m_lanes(m_src)));
        chk("dst_lanes", 32'(dst_lanes), 32'(m_lanes(m_dst)));
        chk("count", 32'(count), 32'(m_cnt[15:0]));
        chk("busy", 32'(busy), 32'(m_busy));
        chk("tc_pulse", 32'(tc_pulse), 32'(m_tc));
        chk("cfg_err", 32'(cfg_err), 32'(m_err));
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic start(logic u, logic r, logic si, logic di,
                         logic [31:0] s, logic [31:0] d, logic [15:0] c);
        en = 1'b0; advance = 1'b0; cyc();
        unit16 = u; ring = r; src_inc = si; dst_inc = di;
        src_start = s; dst_start = d; count_init = c; en = 1'b1;
        cyc();
        // R1: later input changes must not matter
        unit16 = ~u; ring = ~r; src_inc = ~si; dst_inc = ~di;
        src_start = 32'hFFFF_FFFF; dst_start = 32'hFFFF_FFFF; count_init = 16'h7;
    endtask

    task automatic adv(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            advance = 1'b1; cyc();
            if (gaps) begin advance = 1'b0; cyc(); end
        end
        advance = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tag = "R12 reset";
        #1; cmp_all();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc();

        tag = "R1 R2 R3 R6 counted 8-bit";
        start(1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_1001, 32'h0000_2000, 16'd3);
        adv(3, 1'b1);
        adv(3, 1'b0);

        tag = "R2 R4 R5 counted 16-bit";
        start(1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_3003, 32'h0000_4005, 16'd4);
        adv(2, 1'b0);
        adv(3, 1'b1);

        tag = "R7 R9 ring 8-bit";
        start(1'b0, 1'b1, 1'b1, 1'b1, 32'hABCD_0100, 32'h0000_0260, 16'd1);
        adv(40, 1'b0);
        en = 1'b0; advance = 1'b1; cyc(); cyc();
        advance = 1'b0; cyc();

        tag = "R8 R5 ring 16-bit";
        start(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_0005, 16'd0);
        adv(70, 1'b0);
        adv(3, 1'b1);

        tag = "R10 misaligned ring";
        start(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0104, 32'h0000_0003, 16'd5);
        adv(2, 1'b0);
        tag = "R10 misaligned 16-bit window";
        start(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0007, 32'h0000_0220, 16'd5);
        adv(2, 1'b0);
        tag = "R10 fixed misaligned side ok";
        start(1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0013, 32'h0000_0300, 16'd5);
        adv(34, 1'b0);

        tag = "R11 zero count";
        start(1'b0, 1'b0, 1'b1, 1'b1, 32'h10, 32'h20, 16'd0);
        adv(2, 1'b0);

        tag = "R6 single transfer";
        start(1'b1, 1'b0, 1'b0, 1'b1, 32'h40, 32'h81, 16'd1);
        adv(2, 1'b0);
        en = 1'b0; cyc(); cyc();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule